// File: doc/BRIEF.md
# Polled Parallel Bus Peripheral Port

This block is the board-side end of a shared parallel bus that carries an address byte, a data byte, a single data-valid strobe and a poll line. It recognises one address for writes and a second address for reads. A write that is addressed to this board is caught into a local control register. An addressed read places a local status byte onto the bus. All bus lines are open-drain and active-low. They are modelled as a per-line pull-low enable plus a level, and a line that no board drives reads as 1.

The board also raises a wired-OR service request when a local interrupt is pending. The controller answers with a parallel poll: it parks the bus on the reserved address all-ones, raises poll, and then strobes data-valid. Each requesting board pulls its own assigned data line low. The pending flag stays set until the local logic pulses the clear input.

Top module: `pbus_node`

## Requirements
- R1: After reset the control register `ctl_q` is 0x00, no interrupt is pending, `srq_oe` is 0 and no data line is driven.
- R2: A rising edge of `bus_dv`, seen at a clock edge while `bus_addr` equals the write address (default 0x73) and `bus_poll` is 0, loads `bus_d` into `ctl_q`. The new value is visible after that clock edge.
- R3: While `bus_dv` stays high after its rising edge, changes on `bus_d` do not alter `ctl_q`.
- R4: The address 0xFF never selects a write or a read, and neither does any address other than the two decode addresses.
- R5: While `bus_dv` is 1, `bus_poll` is 0 and `bus_addr` equals the read address (default 0xF3, which is the write address with bit 7 set), the board pulls low exactly the lines where `stat_d` has a 0. The resolved bus then equals `stat_d` in the same cycle.
- R6: While `bus_dv` is 0, the board drives no data line.
- R7: When `irq_req` is 1 at a clock edge, the interrupt becomes pending and `srq_oe` is 1 from that edge on.
- R8: A pending interrupt stays set until `irq_clr` is 1 at a clock edge with `irq_req` at 0, and `srq_oe` drops at that edge. When set and clear arrive together, the set wins.
- R9: While `bus_poll` and `bus_dv` are both 1 and an interrupt is pending, only data line POLL_BIT (default 3) is pulled low. With no interrupt pending, a poll drives nothing.
- R10: With `bus_poll` at 1, a strobe at the write or read address neither writes nor reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Bus address byte |
| bus_d | input | 8 | Resolved bus data (1 where undriven) |
| bus_dv | input | 1 | Data-valid strobe, 1 = asserted |
| bus_poll | input | 1 | Parallel poll, 1 = asserted |
| bus_d_oe | output | 8 | Per-line pull-low enable |
| bus_d_o | output | 8 | Level on each line, 0 where enabled |
| srq_oe | output | 1 | Pull-low enable for the shared service request |
| irq_req | input | 1 | Local interrupt request |
| irq_clr | input | 1 | Local interrupt clear pulse |
| ctl_q | output | 8 | Latched control register |
| stat_d | input | 8 | Status byte returned on reads |

## Verification
A wrong edge detector shows up at the first strobe. `ctl_q` either misses the byte or follows later data changes during a held strobe, and this is visible one clock after the change. A faulty decoder shows up within the same cycle as stray pull-low enables on the resolved bus, or as a byte latched for a foreign address. Sweeping all 256 addresses exposes both faults. A stuck or lost pending flag shows one clock after set or clear on `srq_oe`, and as a missing or spurious low line during a poll.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
   localparam int unsigned PB_AW = 8;
   localparam int unsigned PB_DW = 8;

   function automatic logic [PB_AW-1:0] pb_invalid_addr();
      return {PB_AW{1'b1}};
   endfunction

   typedef enum logic [1:0] {
      PB_IDLE  = 2'd0,
      PB_READ  = 2'd1,
      PB_POLL  = 2'd2
   } pb_drive_e;
endpackage

// File: rtl/pbus_decode.sv
module pbus_decode #(
   parameter int unsigned AW      = 8,
   parameter logic [AW-1:0] WR_ADDR = 8'h73,
   parameter logic [AW-1:0] RD_ADDR = 8'hF3
) (
   input  logic [AW-1:0] addr,
   input  logic          poll,
   output logic          wr_sel,
   output logic          rd_sel
);
   localparam logic [AW-1:0] NOADDR = {AW{1'b1}};

   logic addr_ok;

   assign addr_ok = (addr != NOADDR) && !poll;
   assign wr_sel  = addr_ok && (addr == WR_ADDR);
   assign rd_sel  = addr_ok && (addr == RD_ADDR);

   initial begin
      if (WR_ADDR == NOADDR) $error("write address may not be the reserved address");
      if (RD_ADDR == NOADDR) $error("read address may not be the reserved address");
      if (WR_ADDR == RD_ADDR) $error("read and write addresses must differ");
   end

   // R4: the reserved address never selects anything
   a_r4_no_reserved_hit : assert property (@(addr) (addr == NOADDR) |-> !(wr_sel || rd_sel));
   // R10: poll blocks both decodes
   a_r10_poll_blocks : assert property (@(poll) poll |-> !(wr_sel || rd_sel));
endmodule

// File: rtl/pbus_wlatch.sv
module pbus_wlatch #(
   parameter int unsigned DW = 8,
   parameter logic [DW-1:0] RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dv,
   input  logic          sel,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] q
);
   logic dv_q;
   logic take;

   assign take = dv && !dv_q && sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dv_q <= 1'b0;
         q    <= RST_VAL;
      end else begin
         dv_q <= dv;
         if (take) q <= din;
      end
   end

   // R3: no change without a fresh strobe edge
   a_r3_hold_without_edge : assert property (@(posedge clk) disable iff (!rst_n)
      (!dv || dv_q) |=> $stable(q));
   // R2: an addressed edge loads the data
   a_r2_capture : assert property (@(posedge clk) disable iff (!rst_n)
      (dv && !dv_q && sel) |=> (q == $past(din)));
endmodule

// File: rtl/pbus_irq.sv
module pbus_irq #(
   parameter bit CLR_WINS = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic clr,
   output logic pend
);
   logic pend_nx;

   generate
      if (CLR_WINS) begin : g_clr_first
         always_comb begin
            pend_nx = pend;
            if (req) pend_nx = 1'b1;
            if (clr) pend_nx = 1'b0;
         end
      end else begin : g_set_first
         always_comb begin
            pend_nx = pend;
            if (clr) pend_nx = 1'b0;
            if (req) pend_nx = 1'b1;
         end
         // R8: a simultaneous set is never lost
         a_r8_set_wins : assert property (@(posedge clk) disable iff (!rst_n)
            req |=> pend);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= pend_nx;
   end

   // R8: clear without request drops the flag
   a_r8_clear : assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !req) |=> !pend);
   // R8: flag holds without clear or request
   a_r8_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !req) |=> $stable(pend));
endmodule

// File: rtl/pbus_node.sv
module pbus_node #(
   parameter int unsigned AW       = 8,
   parameter int unsigned DW       = 8,
   parameter logic [AW-1:0] WR_ADDR = 8'h73,
   parameter logic [AW-1:0] RD_ADDR = WR_ADDR | (AW'(1) << (AW-1)),
   parameter int unsigned POLL_BIT = 3,
   parameter bit CLR_WINS          = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_d,
   input  logic          bus_dv,
   input  logic          bus_poll,
   output logic [DW-1:0] bus_d_oe,
   output logic [DW-1:0] bus_d_o,
   output logic          srq_oe,
   input  logic          irq_req,
   input  logic          irq_clr,
   output logic [DW-1:0] ctl_q,
   input  logic [DW-1:0] stat_d
);
   import pbus_pkg::*;

   localparam logic [DW-1:0] POLL_MASK = DW'(1) << POLL_BIT;

   logic      wr_sel, rd_sel, pend;
   pb_drive_e mode;

   initial begin
      if (POLL_BIT >= DW) $error("poll bit outside the data bus");
      if (AW != PB_AW) $error("address width differs from bus width");
   end

   pbus_decode #(.AW(AW), .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)) u_dec (
      .addr(bus_addr), .poll(bus_poll), .wr_sel(wr_sel), .rd_sel(rd_sel));

   pbus_wlatch #(.DW(DW), .RST_VAL('0)) u_wl (
      .clk(clk), .rst_n(rst_n), .dv(bus_dv), .sel(wr_sel),
      .din(bus_d), .q(ctl_q));

   pbus_irq #(.CLR_WINS(CLR_WINS)) u_irq (
      .clk(clk), .rst_n(rst_n), .req(irq_req), .clr(irq_clr), .pend(pend));

   always_comb begin
      mode = PB_IDLE;
      if (bus_dv && bus_poll && pend) mode = PB_POLL;
      else if (bus_dv && rd_sel)      mode = PB_READ;
   end

   generate
      for (genvar i = 0; i < DW; i++) begin : g_line
         always_comb begin
            unique case (mode)
               PB_READ: bus_d_oe[i] = !stat_d[i];
               PB_POLL: bus_d_oe[i] = POLL_MASK[i];
               default: bus_d_oe[i] = 1'b0;
            endcase
         end
         assign bus_d_o[i] = !bus_d_oe[i];
      end
   endgenerate

   assign srq_oe = pend;

   // R6: nothing driven without the strobe
   a_r6_quiet_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !bus_dv |-> (bus_d_oe == '0));
   // R9: poll answer is a single line
   a_r9_poll_line : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_dv && bus_poll) |-> ($countones(bus_d_oe) <= 1));
   // R7: request line follows the pending flag one edge after a request
   a_r7_srq : assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |=> srq_oe || CLR_WINS);
endmodule

// File: tb/pbus_node_bench.sv
`timescale 1ns/1ps
module pbus_node_bench;
   localparam logic [7:0] WA = 8'h73;
   localparam logic [7:0] RA = 8'hF3;
   localparam int PB = 3;

   logic clk = 0, rst_n = 0;
   logic [7:0] bus_addr = 8'hFF, bus_dfeed = 8'h00, stat_d = 8'h00;
   logic bus_dv = 0, bus_poll = 0, irq_req = 0, irq_clr = 0;
   logic [7:0] bus_d_oe, bus_d_o, ctl_q, res;
   logic srq_oe;
   int n_run = 0, n_fail = 0;
   logic [7:0] exp_w;

   always #2.5 clk = ~clk;

   pbus_node u_pbus_node (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_d(bus_dfeed),
      .bus_dv(bus_dv), .bus_poll(bus_poll), .bus_d_oe(bus_d_oe),
      .bus_d_o(bus_d_o), .srq_oe(srq_oe), .irq_req(irq_req),
      .irq_clr(irq_clr), .ctl_q(ctl_q), .stat_d(stat_d));

   always_comb for (int i = 0; i < 8; i++) res[i] = bus_d_oe[i] ? bus_d_o[i] : 1'b1;

   task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [7:0] a, input logic [7:0] d, input logic p);
      @(negedge clk); bus_addr = a; bus_dfeed = d; bus_poll = p; bus_dv = 0;
      @(negedge clk); bus_dv = 1;
      @(negedge clk);
   endtask

   task automatic end_strobe();
      bus_dv = 0; @(negedge clk); bus_addr = 8'hFF; bus_poll = 0;
   endtask

   initial begin
      #300000;
      n_fail++; n_run++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 ctl", {1'b0, ctl_q}, 9'h000);
      chk("R1 srq", {8'h0, srq_oe}, 9'h000);
      chk("R1 oe", {1'b0, bus_d_oe}, 9'h000);
      rst_n = 1;
      exp_w = 8'h00;
      // R2 / R4: every address, one write each
      for (int a = 0; a < 256; a++) begin
         do_write(8'(a), 8'(a) ^ 8'hA5, 1'b0);
         if (8'(a) == WA) exp_w = 8'(a) ^ 8'hA5;
         chk((8'(a) == WA) ? "R2 write" : "R4 ignore", {1'b0, ctl_q}, {1'b0, exp_w});
         end_strobe();
      end
      // R3: held strobe, data changes
      do_write(WA, 8'h3C, 1'b0);
      chk("R2 capture", {1'b0, ctl_q}, 9'h03C);
      bus_dfeed = 8'hC3; @(negedge clk); @(negedge clk);
      chk("R3 held strobe", {1'b0, ctl_q}, 9'h03C);
      end_strobe();
      // R10: poll blocks write
      do_write(WA, 8'h11, 1'b1);
      chk("R10 poll write", {1'b0, ctl_q}, 9'h03C);
      chk("R10 poll read", {1'b0, res}, 9'h0FF);
      end_strobe();
      // R5 / R4 / R6: read sweep
      for (int a = 0; a < 256; a++) begin
         @(negedge clk); bus_addr = 8'(a); stat_d = ~8'(a) ^ 8'h0F; bus_dv = 0;
         #1 chk("R6 idle", {1'b0, bus_d_oe}, 9'h000);
         @(negedge clk); bus_dv = 1;
         #1 chk((8'(a) == RA) ? "R5 read" : "R4 no read", {1'b0, res},
                (8'(a) == RA) ? {1'b0, stat_d} : 9'h0FF);
         bus_dv = 0;
      end
      @(negedge clk); bus_addr = RA; stat_d = 8'h00; bus_poll = 1; bus_dv = 1;
      #1 chk("R10 poll read", {1'b0, res}, 9'h0FF);
      bus_addr = 8'hFF;
      #1 chk("R9 no pending poll", {1'b0, bus_d_oe}, 9'h000);
      bus_dv = 0; bus_poll = 0;
      // R7 / R8
      @(negedge clk); irq_req = 1;
      @(negedge clk); irq_req = 0;
      chk("R7 srq", {8'h0, srq_oe}, 9'h001);
      repeat (4) @(negedge clk);
      chk("R8 hold", {8'h0, srq_oe}, 9'h001);
      bus_poll = 1; bus_dv = 1;
      #1 chk("R9 poll line", {1'b0, res}, {1'b0, ~(8'h01 << PB)});
      @(negedge clk); bus_dv = 0; bus_poll = 0;
      irq_req = 1; irq_clr = 1;
      @(negedge clk); irq_req = 0;
      chk("R8 set wins", {8'h0, srq_oe}, 9'h001);
      @(negedge clk); irq_clr = 0;
      chk("R8 clear", {8'h0, srq_oe}, 9'h000);
      bus_poll = 1; bus_dv = 1;
      #1 chk("R9 cleared poll", {1'b0, bus_d_oe}, 9'h000);
      bus_poll = 0; bus_dv = 0;
      @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule